// File: doc/BRIEF.md
# Calibration Trigger and Busy Sequencer

This block decides when a converter calibration runs, which trim phases it passes through, and how long the busy flag stays up. There are two ways to request a calibration. The first is a rising edge on an active-low calibration pin. The second is a register write that carries a start flag. The block steps through the trim phases of the chosen calibration type. It raises one phase-enable at a time for the analog trim logic, which lies outside this block. It holds busy high for the exact number of master clocks that belong to that type.

While the calibration pin is low, the sequencer is held in reset. Any running calibration is aborted and register writes are refused. The type register reloads "full" on the block reset. Strapping works as follows:
- If the pin is held high through reset, no automatic calibration runs.
- If the pin is low at reset and rises later, for example through an external capacitor, a full calibration runs once.

The offset phase aims at midscale for bipolar input and at zero scale for unipolar input. The polarity is captured when the calibration starts.

Top module: `cal_sequencer`

## Requirements
- R1: After the block reset, busy, trimDac, trimOffset, trimGain and ofsMid are all low.
- R2: A rising edge of calPin starts a calibration of the stored type. Busy is low at the first clock edge after the rise and high after the second.
- R3: A write (wrEn high) always loads wrType into the stored type. If wrStart is also set, busy is high after the first clock edge. If wrStart is clear, no calibration starts. Type codes are 00 full, 01 gain+offset, 10 offset only, 11 gain only.
- R4: A full calibration runs the DAC phase for FULL_DAC_CLKS clocks, then offset for FULL_OFS_CLKS, then gain for FULL_GAIN_CLKS. Busy is high for exactly the sum of the three.
- R5: A gain+offset calibration runs gain for PAIR_GAIN_CLKS, then offset for PAIR_OFS_CLKS, and has no DAC phase.
- R6: An offset-only calibration runs a single offset phase of OFS_ONLY_CLKS clocks.
- R7: A gain-only calibration runs a single gain phase of GAIN_ONLY_CLKS clocks.
- R8: While busy is high, exactly one of trimDac, trimOffset and trimGain is high. While busy is low, none of them is high.
- R9: During the offset phase, ofsMid equals the bipolar input as sampled when the calibration started. Later changes to bipolar have no effect.
- R10: A low level on calPin aborts a running calibration, so busy is low after the second clock edge. Writes are ignored while the pin is low, including their type.
- R11: A write that arrives while busy is high has no effect on the running sequence or on the stored type.
- R12: With calPin high through reset, no calibration starts. With calPin low at reset and rising later, a full calibration runs, whatever type was stored before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| calPin | input | 1 | Calibration pin; low holds the sequencer in reset, and the rising edge starts a calibration |
| wrEn | input | 1 | One-cycle register write strobe |
| wrStart | input | 1 | Start flag carried by the write |
| wrType | input | 2 | Calibration type carried by the write |
| bipolar | input | 1 | Input polarity mode, sampled at calibration start |
| busy | output | 1 | High while a calibration runs |
| trimDac | output | 1 | DAC capacitor trim phase enable |
| trimOffset | output | 1 | Offset trim phase enable |
| trimGain | output | 1 | Gain trim phase enable |
| ofsMid | output | 1 | Offset target select: high for midscale, low for zero scale |

## Verification
The hardest situations to reach are the ones that collide with a running calibration: a pin drop in the middle of a phase, and a write that lands while busy is high. Neither changes the busy length in an obvious way. The bench first records a baseline phase trace for every type and polarity. It then starts a full calibration and, a few cycles in, either issues a conflicting start write or pulls the pin low and writes during the low period. Afterwards it triggers again from the pin and compares the new trace against the full-type trace. This shows at the ports whether a refused write leaked into the stored type.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    CAL_FULL     = 2'b00,
    CAL_GAIN_OFS = 2'b01,
    CAL_OFS      = 2'b10,
    CAL_GAIN     = 2'b11
  } calType_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_DAC  = 2'b01,
    PH_OFS  = 2'b10,
    PH_GAIN = 2'b11
  } phase_e;

  // strobes from control to the clock-count datapath
  typedef struct packed {
    logic     load;
    phase_e   phase;
    calType_e calType;
  } seqStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cal_seq_count.sv
module cal_seq_count
  import cal_seq_pkg::*;
#(
  parameter int FULL_DAC_CLKS  = 97253,
  parameter int FULL_OFS_CLKS  = 13880,
  parameter int FULL_GAIN_CLKS = 13880,
  parameter int PAIR_GAIN_CLKS = 13880,
  parameter int PAIR_OFS_CLKS  = 13880,
  parameter int OFS_ONLY_CLKS  = 13880,
  parameter int GAIN_ONLY_CLKS = 13880
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       lastCycle
);

  localparam int MAX_LEN = maxOf(maxOf(maxOf(FULL_DAC_CLKS, FULL_OFS_CLKS),
                                       maxOf(FULL_GAIN_CLKS, PAIR_GAIN_CLKS)),
                                 maxOf(maxOf(PAIR_OFS_CLKS, OFS_ONLY_CLKS),
                                       GAIN_ONLY_CLKS));
  localparam int CW = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;
  int            phaseLen;

  always_comb begin
    phaseLen = 1;
    unique case ({strb.calType, strb.phase})
      {CAL_FULL,     PH_DAC }: phaseLen = FULL_DAC_CLKS;
      {CAL_FULL,     PH_OFS }: phaseLen = FULL_OFS_CLKS;
      {CAL_FULL,     PH_GAIN}: phaseLen = FULL_GAIN_CLKS;
      {CAL_GAIN_OFS, PH_GAIN}: phaseLen = PAIR_GAIN_CLKS;
      {CAL_GAIN_OFS, PH_OFS }: phaseLen = PAIR_OFS_CLKS;
      {CAL_OFS,      PH_OFS }: phaseLen = OFS_ONLY_CLKS;
      {CAL_GAIN,     PH_GAIN}: phaseLen = GAIN_ONLY_CLKS;
      default:                 phaseLen = 1;
    endcase
    loadVal = CW'(phaseLen - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.load)     cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign lastCycle = (cnt == '0);

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       calPin,
  input  logic       wrEn,
  input  logic       wrStart,
  input  logic [1:0] wrType,
  input  logic       bipolar,
  input  logic       lastCycle,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       trimDac,
  output logic       trimOffset,
  output logic       trimGain,
  output logic       ofsMid
);

  phase_e   phase, nextPhase, firstPhase;
  calType_e storedType, curType, selType, useType;
  logic     pinS, pinD, biLatch;
  logic     pinRise, accept, wrAccept, start;

  always_comb begin
    pinRise  = pinS & ~pinD;
    accept   = pinS & (phase == PH_IDLE);
    wrAccept = wrEn & accept;
    start    = accept & (pinRise | (wrAccept & wrStart));
    selType  = wrAccept ? calType_e'(wrType) : storedType;

    unique case (selType)
      CAL_FULL:     firstPhase = PH_DAC;
      CAL_GAIN_OFS: firstPhase = PH_GAIN;
      CAL_OFS:      firstPhase = PH_OFS;
      default:      firstPhase = PH_GAIN;
    endcase

    nextPhase = phase;
    if (!pinS) begin
      nextPhase = PH_IDLE;
    end else if (phase == PH_IDLE) begin
      nextPhase = start ? firstPhase : PH_IDLE;
    end else if (lastCycle) begin
      unique case (phase)
        PH_DAC:  nextPhase = PH_OFS;
        PH_OFS:  nextPhase = (curType == CAL_FULL) ? PH_GAIN : PH_IDLE;
        PH_GAIN: nextPhase = (curType == CAL_GAIN_OFS) ? PH_OFS : PH_IDLE;
        default: nextPhase = PH_IDLE;
      endcase
    end

    useType      = (phase == PH_IDLE) ? selType : curType;
    strb.load    = (nextPhase != PH_IDLE) && (nextPhase != phase);
    strb.phase   = nextPhase;
    strb.calType = useType;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS       <= 1'b1;
      pinD       <= 1'b1;
      phase      <= PH_IDLE;
      storedType <= CAL_FULL;
      curType    <= CAL_FULL;
      biLatch    <= 1'b0;
    end else begin
      pinS  <= calPin;
      pinD  <= pinS;
      phase <= nextPhase;
      if (wrAccept) storedType <= calType_e'(wrType);
      if (start) begin
        curType <= selType;
        biLatch <= bipolar;
      end
    end
  end

  assign busy       = (phase != PH_IDLE);
  assign trimDac    = (phase == PH_DAC);
  assign trimOffset = (phase == PH_OFS);
  assign trimGain   = (phase == PH_GAIN);
  assign ofsMid     = trimOffset & biLatch;

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int FULL_DAC_CLKS  = 97253,
  parameter int FULL_OFS_CLKS  = 13880,
  parameter int FULL_GAIN_CLKS = 13880,
  parameter int PAIR_GAIN_CLKS = 13880,
  parameter int PAIR_OFS_CLKS  = 13880,
  parameter int OFS_ONLY_CLKS  = 13880,
  parameter int GAIN_ONLY_CLKS = 13880
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calPin,
  input  logic       wrEn,
  input  logic       wrStart,
  input  logic [1:0] wrType,
  input  logic       bipolar,
  output logic       busy,
  output logic       trimDac,
  output logic       trimOffset,
  output logic       trimGain,
  output logic       ofsMid
);

  seqStrobe_t strb;
  logic       lastCycle;

  cal_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .calPin    (calPin),
    .wrEn      (wrEn),
    .wrStart   (wrStart),
    .wrType    (wrType),
    .bipolar   (bipolar),
    .lastCycle (lastCycle),
    .strb      (strb),
    .busy      (busy),
    .trimDac   (trimDac),
    .trimOffset(trimOffset),
    .trimGain  (trimGain),
    .ofsMid    (ofsMid)
  );

  cal_seq_count #(
    .FULL_DAC_CLKS (FULL_DAC_CLKS),
    .FULL_OFS_CLKS (FULL_OFS_CLKS),
    .FULL_GAIN_CLKS(FULL_GAIN_CLKS),
    .PAIR_GAIN_CLKS(PAIR_GAIN_CLKS),
    .PAIR_OFS_CLKS (PAIR_OFS_CLKS),
    .OFS_ONLY_CLKS (OFS_ONLY_CLKS),
    .GAIN_ONLY_CLKS(GAIN_ONLY_CLKS)
  ) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lastCycle(lastCycle)
  );

endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic calPin,
  input logic wrEn,
  input logic wrStart,
  input logic busy,
  input logic trimDac,
  input logic trimOffset,
  input logic trimGain
);

  AST_ONE_TRIM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $countones({trimDac, trimOffset, trimGain}) == 1);  // R8

  AST_NO_TRIM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(trimDac || trimOffset || trimGain));  // R8

  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStart && !busy && $past(rstN) && $past(calPin)) |=> busy);  // R3

  AST_PIN_LOW_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(calPin)) |=> !busy);  // R10

  AST_DAC_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trimDac) |-> !$past(busy));  // R4

  AST_DAC_THEN_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(trimDac) && busy) |-> trimOffset);  // R4

endmodule

bind cal_sequencer cal_sequencer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .calPin    (calPin),
  .wrEn      (wrEn),
  .wrStart   (wrStart),
  .busy      (busy),
  .trimDac   (trimDac),
  .trimOffset(trimOffset),
  .trimGain  (trimGain)
);

// File: tb/cal_sequencer_tb.sv
module cal_sequencer_tb;

  localparam int TCLK = 10;
  localparam int L_FDAC = 5, L_FOFS = 3, L_FGAIN = 4;
  localparam int L_PGAIN = 2, L_POFS = 6;
  localparam int L_OFS = 7, L_GAIN = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calPin = 1'b1;
  logic wrEn = 1'b0, wrStart = 1'b0, bipolar = 1'b0;
  logic [1:0] wrType = 2'b00;
  logic busy, trimDac, trimOffset, trimGain, ofsMid;

  int checks = 0, errors = 0;
  int seqCode[8], seqLen[8];
  int nSeq, total, midBad, trimBad;

  always #(TCLK/2) clk = ~clk;

  cal_sequencer #(
    .FULL_DAC_CLKS(L_FDAC), .FULL_OFS_CLKS(L_FOFS), .FULL_GAIN_CLKS(L_FGAIN),
    .PAIR_GAIN_CLKS(L_PGAIN), .PAIR_OFS_CLKS(L_POFS),
    .OFS_ONLY_CLKS(L_OFS), .GAIN_ONLY_CLKS(L_GAIN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .calPin(calPin), .wrEn(wrEn), .wrStart(wrStart),
    .wrType(wrType), .bipolar(bipolar), .busy(busy), .trimDac(trimDac),
    .trimOffset(trimOffset), .trimGain(trimGain), .ofsMid(ofsMid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // trace one calibration from the current negedge (busy already high) to its end
  task automatic capture(input int pre, input bit bi);
    int code, guard;
    nSeq = 0; total = 0; midBad = 0; trimBad = 0; guard = 0;
    while (busy && guard < 1000) begin
      code = trimDac ? 1 : trimOffset ? 2 : trimGain ? 3 : 0;
      if ($countones({trimDac, trimOffset, trimGain}) != 1) trimBad++;
      if (trimOffset && (ofsMid != bi)) midBad++;
      if (nSeq == 0 || seqCode[nSeq-1] != code) begin
        if (nSeq < 8) begin seqCode[nSeq] = code; seqLen[nSeq] = 0; nSeq++; end
      end
      seqLen[nSeq-1]++;
      total++; guard++;
      @(negedge clk);
    end
    total += pre;
    if (nSeq > 0) seqLen[0] += pre;
  endtask

  task automatic expectSeq(input string req, input int t, input bit bi);
    int eCode[3], eLen[3];
    int eN, eTot;
    case (t)
      0: begin eN = 3; eCode = '{1, 2, 3}; eLen = '{L_FDAC, L_FOFS, L_FGAIN}; end
      1: begin eN = 2; eCode = '{3, 2, 0}; eLen = '{L_PGAIN, L_POFS, 0}; end
      2: begin eN = 1; eCode = '{2, 0, 0}; eLen = '{L_OFS, 0, 0}; end
      default: begin eN = 1; eCode = '{3, 0, 0}; eLen = '{L_GAIN, 0, 0}; end
    endcase
    eTot = eLen[0] + eLen[1] + eLen[2];
    check(nSeq == eN, {req, " phase count"}, nSeq, eN);
    for (int i = 0; i < eN && i < nSeq; i++) begin
      check(seqCode[i] == eCode[i], {req, " phase order"}, seqCode[i], eCode[i]);
      check(seqLen[i] == eLen[i], {req, " phase length"}, seqLen[i], eLen[i]);
    end
    check(total == eTot, {req, " busy length"}, total, eTot);
    check(trimBad == 0, "R8 one enable while busy", trimBad, 0);
    check(midBad == 0, "R9 offset target", midBad, 0);
    check(!(trimDac || trimOffset || trimGain || ofsMid), "R8 idle enables",
          {trimDac, trimOffset, trimGain, ofsMid}, 0);
    if (bi && (t != 3)) check(1'b1, "R9 exercised", 1, 1);
  endtask

  task automatic doWrite(input int t, input bit st);
    wrEn = 1'b1; wrStart = st; wrType = 2'(t);
    @(negedge clk);
    wrEn = 1'b0; wrStart = 1'b0;
  endtask

  task automatic pinPulse();
    calPin = 1'b0;
    repeat (3) @(negedge clk);
    calPin = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R2 busy not before second edge", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy by second edge", busy, 1);
  endtask

  initial begin
    #(TCLK * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    string reqs[4] = '{"R4", "R5", "R6", "R7"};
    int seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check({trimDac, trimOffset, trimGain, ofsMid} == 4'b0, "R1 enables after reset",
          {trimDac, trimOffset, trimGain, ofsMid}, 0);
    seen = 0;
    repeat (20) begin @(negedge clk); if (busy) seen++; end
    check(seen == 0, "R12 strapped high skips auto calibration", seen, 0);

    // sweep every type in both polarities via register writes
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 2; b++) begin
        bipolar = b[0];
        doWrite(t, 1'b1);
        check(busy == 1'b1, "R3 write start busy after first edge", busy, 1);
        bipolar = ~b[0];
        capture(0, b[0]);
        expectSeq(reqs[t], t, b[0]);
        repeat (2) @(negedge clk);
      end
    end

    // type-only write, then pin trigger uses it
    doWrite(2, 1'b0);
    seen = 0;
    repeat (5) begin if (busy) seen++; @(negedge clk); end
    check(seen == 0, "R3 write without start", seen, 0);
    bipolar = 1'b1;
    pinPulse();
    capture(0, 1'b1);
    expectSeq("R2", 2, 1'b1);

    // R11: conflicting write during a full run
    repeat (2) @(negedge clk);
    bipolar = 1'b0;
    doWrite(0, 1'b1);
    doWrite(3, 1'b1);
    capture(1, 1'b0);
    expectSeq("R11", 0, 1'b0);
    repeat (2) @(negedge clk);
    pinPulse();
    capture(0, 1'b0);
    expectSeq("R11 stored type kept", 0, 1'b0);

    // R10: pin drop aborts, writes refused while low
    repeat (2) @(negedge clk);
    doWrite(0, 1'b1);
    repeat (3) @(negedge clk);
    calPin = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R10 busy until second edge", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R10 abort", busy, 0);
    check({trimDac, trimOffset, trimGain} == 3'b0, "R10 enables cleared",
          {trimDac, trimOffset, trimGain}, 0);
    doWrite(1, 1'b1);
    seen = 0;
    repeat (4) begin if (busy) seen++; @(negedge clk); end
    check(seen == 0, "R10 write ignored while pin low", seen, 0);
    calPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R10 restart on rise", busy, 1);
    capture(0, 1'b0);
    expectSeq("R10 type unchanged", 0, 1'b0);

    // R12: pin low through reset, later rise gives full calibration
    repeat (2) @(negedge clk);
    doWrite(3, 1'b0);
    calPin = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    seen = 0;
    repeat (10) begin @(negedge clk); if (busy) seen++; end
    check(seen == 0, "R12 no start while pin low", seen, 0);
    calPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R12 auto calibration starts", busy, 1);
    capture(0, 1'b0);
    expectSeq("R12", 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule